// File: doc/BRIEF.md
# Range ANS Symbol Decoder

This block decodes a range asymmetric numeral system stream. It keeps a 64-bit state that is loaded from two 32-bit words of the input stream, low word first. While the block is idle it drives the low `scale` bits of the state as a slot value. External logic maps that slot to a symbol and returns the symbol's range start and frequency with an advance command. The block then replaces the state with `freq * (x >> scale) + (x & mask) - start`. When the new state falls below 2^31, it pulls exactly one more 32-bit word and appends it below the state.

Commands use a valid/ready handshake with a 2-bit opcode:

| Opcode | Name | Action |
|---|---|---|
| 0 | init | load a new state |
| 1 | advance | advance, then refill if needed |
| 2 | step | advance without refill |
| 3 | renormalize | refill only |

Input words arrive on their own valid/ready stream and are consumed in forward order. While a refill is pending, command ready stays low, so the next symbol is held off until a word has arrived. The block raises a sticky error flag in two cases: when the symbol parameters are out of range, and when a refill fails to lift the state to 2^31. The full state is also driven out, so it can be saved or interleaved with other decoder states.

Top module: `rans_dec`

## Requirements
- R1: After reset the state is 0, `cmd_ready_o` is 1, `word_ready_o` is 0 and `err_o` is 0.
- R2: An accepted opcode 0 lowers `cmd_ready_o` and raises `word_ready_o`. The first accepted word becomes state bits 31:0 and the second becomes bits 63:32. `cmd_ready_o` returns high in the cycle after the second word is accepted.
- R3: `slot_o` equals the state ANDed with 2^scale-1, combinationally in `scale_i`, for every scale from 0 to 31.
- R4: An accepted opcode 1 with valid parameters sets the state to `freq*(x>>scale) + (x & (2^scale-1)) - start`, modulo 2^64.
- R5: If the opcode 1 result is below 2^31, the block holds `cmd_ready_o` low and `word_ready_o` high until one word is accepted. The state then becomes `(result << 32) | word`, and no further word is taken for that symbol.
- R6: Opcode 2 applies the R4 arithmetic and never refills. The state is left as computed even when it is below 2^31, and `cmd_ready_o` stays high.
- R7: Opcode 3 refills as in R5 when the state is below 2^31. Otherwise it changes nothing and consumes no word.
- R8: For opcodes 1 and 2, each of the following sets `err_o` and leaves the state unchanged with no word consumed:
  - freq = 0;
  - start > 2^scale;
  - freq > 2^scale - start.
- R9: If a refilled state is still below 2^31, `err_o` is set. The refilled value is kept.
- R10: `err_o` stays set until an opcode 0 is accepted, which clears it.
- R11: While idle, `word_ready_o` is 0. An offered word is neither consumed nor able to change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scale_i | input | 5 | Log2 of the total frequency |
| cmd_valid_i | input | 1 | Command valid |
| cmd_op_i | input | 2 | Opcode: 0 init, 1 advance, 2 step, 3 renormalize |
| cmd_start_i | input | 32 | Symbol range start |
| cmd_freq_i | input | 32 | Symbol frequency |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| word_valid_i | input | 1 | Input word valid |
| word_i | input | 32 | Input word |
| word_ready_o | output | 1 | Word accepted when high with valid |
| slot_o | output | 32 | Low scale bits of the state |
| state_o | output | 64 | Current decoder state |
| err_o | output | 1 | Sticky error flag |

## Verification
The hardest condition to reach from the ports is a refill that leaves the state below 2^31. With well-formed symbols the advanced state is almost never zero, and a zero state is the only way the appended word cannot lift it past 2^31. The stimulus gets there directly: it initializes an all-zero state, issues a renormalize, and supplies a word with bit 31 clear. Refills under ordinary traffic come from long sweeps at several scales. These sweeps pick each symbol's range so that it contains the slot, and mix step commands with small frequencies at high scales. The mix drives the state below 2^31 frequently, and each resulting stall is held for several cycles before its word is supplied.

// File: rtl/rans_dec_pkg.sv
package rans_dec_pkg;
  typedef enum logic [1:0] {
    OP_INIT   = 2'd0,
    OP_ADV    = 2'd1,
    OP_STEP   = 2'd2,
    OP_RENORM = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_FILL
  } fsm_e;

  typedef enum logic [2:0] {
    UPD_NONE,
    UPD_LO,
    UPD_HI,
    UPD_ADV,
    UPD_FILL
  } upd_e;
endpackage

// File: rtl/rans_dec_arith.sv
module rans_dec_arith #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SCALE_W = 5
) (
  input  logic [2*WORD_W-1:0] state_i,
  input  logic [SCALE_W-1:0]  scale_i,
  input  logic [WORD_W-1:0]   start_i,
  input  logic [WORD_W-1:0]   freq_i,
  output logic [WORD_W-1:0]   slot_o,
  output logic [2*WORD_W-1:0] adv_o,
  output logic                below_o,
  output logic                adv_below_o,
  output logic                param_err_o
);
  localparam int unsigned XW = 2 * WORD_W;
  localparam logic [XW-1:0] LOW = XW'(1) << (WORD_W - 1);

  logic [XW-1:0] total, mask, start_x, freq_x, prod;

  always_comb begin
    total   = XW'(1) << scale_i;
    mask    = total - XW'(1);
    start_x = XW'(start_i);
    freq_x  = XW'(freq_i);
    prod    = freq_x * (state_i >> scale_i);
    adv_o   = prod + (state_i & mask) - start_x;
    slot_o  = WORD_W'(state_i & mask);
    below_o     = state_i < LOW;
    adv_below_o = adv_o < LOW;
    param_err_o = (freq_i == '0) || (start_x > total) || (freq_x > (total - start_x));
  end
endmodule

// File: rtl/rans_dec_ctrl.sv
module rans_dec_ctrl
  import rans_dec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  op_e  op_i,
  input  logic param_err_i,
  input  logic below_i,
  input  logic adv_below_i,
  input  logic word_valid_i,
  output logic cmd_ready_o,
  output logic word_ready_o,
  output logic cmd_fire_o,
  output upd_e upd_o
);
  fsm_e fsm_q, fsm_d;
  logic word_fire;

  assign cmd_ready_o  = (fsm_q == ST_IDLE);
  assign word_ready_o = (fsm_q != ST_IDLE);
  assign cmd_fire_o   = cmd_valid_i & cmd_ready_o;
  assign word_fire    = word_valid_i & word_ready_o;

  always_comb begin
    fsm_d = fsm_q;
    upd_o = UPD_NONE;
    unique case (fsm_q)
      ST_IDLE: if (cmd_fire_o) begin
        unique case (op_i)
          OP_INIT:   fsm_d = ST_LO;
          OP_ADV:    if (!param_err_i) begin
                       upd_o = UPD_ADV;
                       if (adv_below_i) fsm_d = ST_FILL;
                     end
          OP_STEP:   if (!param_err_i) upd_o = UPD_ADV;
          OP_RENORM: if (below_i) fsm_d = ST_FILL;
          default:   fsm_d = ST_IDLE;
        endcase
      end
      ST_LO: if (word_fire) begin
        upd_o = UPD_LO;
        fsm_d = ST_HI;
      end
      ST_HI: if (word_fire) begin
        upd_o = UPD_HI;
        fsm_d = ST_IDLE;
      end
      ST_FILL: if (word_fire) begin
        upd_o = UPD_FILL;
        fsm_d = ST_IDLE;
      end
      default: fsm_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fsm_q <= ST_IDLE;
    else         fsm_q <= fsm_d;
  end

  // R5
  refill_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == ST_FILL && !word_valid_i) |=> (fsm_q == ST_FILL && !cmd_ready_o));

  // R11
  idle_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == ST_IDLE && !cmd_valid_i) |=> (fsm_q == ST_IDLE && upd_o != UPD_FILL));
endmodule

// File: rtl/rans_dec.sv
module rans_dec
  import rans_dec_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SCALE_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SCALE_W-1:0]  scale_i,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [WORD_W-1:0]   cmd_start_i,
  input  logic [WORD_W-1:0]   cmd_freq_i,
  output logic                cmd_ready_o,
  input  logic                word_valid_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic                word_ready_o,
  output logic [WORD_W-1:0]   slot_o,
  output logic [2*WORD_W-1:0] state_o,
  output logic                err_o
);
  localparam int unsigned XW = 2 * WORD_W;
  localparam logic [XW-1:0] LOW = XW'(1) << (WORD_W - 1);

  op_e           op;
  upd_e          upd;
  logic [XW-1:0] state_q, state_d, adv, fill_val;
  logic          below, adv_below, param_err, cmd_fire, err_q, err_d;

  assign op       = op_e'(cmd_op_i);
  assign fill_val = {state_q[WORD_W-1:0], word_i};

  rans_dec_arith #(.WORD_W(WORD_W), .SCALE_W(SCALE_W)) u_arith (
    .state_i     (state_q),
    .scale_i     (scale_i),
    .start_i     (cmd_start_i),
    .freq_i      (cmd_freq_i),
    .slot_o      (slot_o),
    .adv_o       (adv),
    .below_o     (below),
    .adv_below_o (adv_below),
    .param_err_o (param_err)
  );

  rans_dec_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .op_i         (op),
    .param_err_i  (param_err),
    .below_i      (below),
    .adv_below_i  (adv_below),
    .word_valid_i (word_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .word_ready_o (word_ready_o),
    .cmd_fire_o   (cmd_fire),
    .upd_o        (upd)
  );

  always_comb begin
    state_d = state_q;
    unique case (upd)
      UPD_LO:   state_d = {state_q[XW-1:WORD_W], word_i};
      UPD_HI:   state_d = {word_i, state_q[WORD_W-1:0]};
      UPD_ADV:  state_d = adv;
      UPD_FILL: state_d = fill_val;
      default:  state_d = state_q;
    endcase
  end

  always_comb begin
    err_d = err_q;
    if (cmd_fire && op == OP_INIT)                                     err_d = 1'b0;
    else if (cmd_fire && (op == OP_ADV || op == OP_STEP) && param_err) err_d = 1'b1;
    else if (upd == UPD_FILL && fill_val < LOW)                        err_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

  // R2
  init_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd == UPD_HI) |=> (state_q[XW-1:WORD_W] == $past(word_i)));

  // R5
  fill_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd == UPD_FILL) |=> (state_q == {$past(state_q[WORD_W-1:0]), $past(word_i)}));

  // R9
  fill_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd == UPD_FILL) |=> (state_q >= LOW || err_q));

  // R8
  param_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && (op == OP_ADV || op == OP_STEP) && param_err) |=> (err_q && $stable(state_q)));

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(cmd_fire && op == OP_INIT)) |=> err_q);

  // R3
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slot_o >> scale_i) == '0));
endmodule

// File: tb/rans_dec_tb.sv
module rans_dec_tb;
  localparam logic [63:0] LOW = 64'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  scale = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_start = '0, cmd_freq = '0;
  logic        cmd_ready;
  logic        word_valid = 1'b0;
  logic [31:0] word = '0;
  logic        word_ready;
  logic [31:0] slot;
  logic [63:0] state;
  logic        err;

  int total = 0, fails = 0;
  logic [63:0] ex, xn, m, sl, a, st, fr;
  logic        exp_err;
  logic [31:0] rnd = 32'h1234_5678;
  logic [31:0] w;

  always #4 clk = ~clk;

  rans_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scale_i(scale),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_start_i(cmd_start), .cmd_freq_i(cmd_freq),
    .cmd_ready_o(cmd_ready), .word_valid_i(word_valid), .word_i(word), .word_ready_o(word_ready),
    .slot_o(slot), .state_o(state), .err_o(err)
  );

  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] t = v;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  function automatic logic [63:0] adv_f(input logic [63:0] x, input int s,
                                        input logic [63:0] sa, input logic [63:0] f);
    logic [63:0] mk = (64'd1 << s) - 64'd1;
    return f * (x >> s) + (x & mk) - sa;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] s, input logic [31:0] f);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_start = s; cmd_freq = f;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] v);
    @(negedge clk);
    word_valid = 1'b1; word = v;
    while (!word_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic do_init(input logic [31:0] lo, input logic [31:0] hi);
    do_cmd(2'd0, '0, '0);
    chk("R2 ready low", {63'd0, cmd_ready}, 64'd0);
    chk("R2 word ready", {63'd0, word_ready}, 64'd1);
    send_word(lo);
    chk("R2 mid ready", {63'd0, cmd_ready}, 64'd0);
    send_word(hi);
    chk("R2 state", state, {hi, lo});
    chk("R2 ready back", {63'd0, cmd_ready}, 64'd1);
    chk("R10 err cleared", {63'd0, err}, 64'd0);
    ex = {hi, lo};
    exp_err = 1'b0;
  endtask

  task automatic fill_expected();
    chk("R5 stall cmd", {63'd0, cmd_ready}, 64'd0);
    chk("R5 stall word", {63'd0, word_ready}, 64'd1);
    repeat (2) @(negedge clk);
    chk("R5 still stalled", {63'd0, cmd_ready}, 64'd0);
    rnd = nxt(rnd); w = rnd;
    send_word(w);
    ex = {ex[31:0], w};
    if (ex < LOW) exp_err = 1'b1;
    chk("R5 refill", state, ex);
    chk("R5 one word", {63'd0, word_ready}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", state, 64'd0);
    chk("R1 cmd_ready", {63'd0, cmd_ready}, 64'd1);
    chk("R1 word_ready", {63'd0, word_ready}, 64'd0);
    chk("R1 err", {63'd0, err}, 64'd0);

    do_init(32'h89AB_CDEF, 32'h0123_4567);

    // R3 exhaustive scale sweep
    for (int s = 0; s < 32; s++) begin
      scale = 5'(s);
      #1;
      chk("R3 slot", {32'd0, slot}, ex & ((64'd1 << s) - 64'd1));
    end

    // R11 idle words ignored
    @(negedge clk);
    word_valid = 1'b1; word = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    chk("R11 word_ready idle", {63'd0, word_ready}, 64'd0);
    chk("R11 state kept", state, ex);
    word_valid = 1'b0;

    // main sweep R4 R5 R6 R7
    for (int si = 0; si < 7; si++) begin
      int sc;
      case (si)
        0: sc = 1; 1: sc = 3; 2: sc = 8; 3: sc = 12;
        4: sc = 16; 5: sc = 24; default: sc = 31;
      endcase
      rnd = nxt(rnd); w = rnd;
      rnd = nxt(rnd);
      do_init(w, rnd | 32'h1);
      scale = 5'(sc);
      for (int k = 0; k < 40; k++) begin
        m  = 64'd1 << sc;
        sl = ex & (m - 64'd1);
        #1;
        chk("R3 slot sweep", {32'd0, slot}, sl);
        rnd = nxt(rnd); a = 64'(rnd) % (sl + 64'd1);
        st = sl - a;
        rnd = nxt(rnd); fr = a + 64'd1 + 64'(rnd) % (m - sl);
        if (k % 8 == 7) begin
          xn = adv_f(ex, sc, st, fr);
          do_cmd(2'd2, st[31:0], fr[31:0]);
          ex = xn;
          chk("R6 step state", state, ex);
          chk("R6 no refill", {63'd0, cmd_ready}, 64'd1);
          do_cmd(2'd3, '0, '0);
          if (ex < LOW) fill_expected();
          else begin
            chk("R7 no word", {63'd0, word_ready}, 64'd0);
            chk("R7 unchanged", state, ex);
          end
        end else begin
          xn = adv_f(ex, sc, st, fr);
          do_cmd(2'd1, st[31:0], fr[31:0]);
          ex = xn;
          if (ex < LOW) fill_expected();
          else chk("R4 advance", state, ex);
        end
        chk("R9 err model", {63'd0, err}, {63'd0, exp_err});
      end
    end

    // R8 parameter errors
    do_init(32'h0000_0100, 32'h0000_0001);
    scale = 5'd4;
    do_cmd(2'd1, 32'd0, 32'd0);
    chk("R8 freq zero err", {63'd0, err}, 64'd1);
    chk("R8 state held", state, ex);
    chk("R8 no word", {63'd0, word_ready}, 64'd0);
    do_init(32'h0000_0100, 32'h0000_0001);
    chk("R10 cleared by init", {63'd0, err}, 64'd0);
    do_cmd(2'd2, 32'd17, 32'd1);
    chk("R8 start high err", {63'd0, err}, 64'd1);
    chk("R8 state held", state, ex);
    do_cmd(2'd1, 32'd0, 32'd16);
    chk("R10 sticky", {63'd0, err}, 64'd1);
    do_init(32'h0000_0100, 32'h0000_0001);
    do_cmd(2'd1, 32'd10, 32'd7);
    chk("R8 freq over err", {63'd0, err}, 64'd1);
    do_init(32'h0000_0100, 32'h0000_0001);
    do_cmd(2'd1, 32'd16, 32'd1);
    chk("R8 start eq total err", {63'd0, err}, 64'd1);
    do_init(32'h0000_0100, 32'h0000_0001);
    xn = adv_f(ex, 4, 64'd0, 64'd16);
    do_cmd(2'd2, 32'd0, 32'd16);
    chk("R8 full range ok", {63'd0, err}, 64'd0);
    chk("R4 full range", state, xn);

    // R9 refill that stays low
    do_init(32'h0, 32'h0);
    do_cmd(2'd3, '0, '0);
    chk("R7 renorm stalls", {63'd0, word_ready}, 64'd1);
    send_word(32'h0000_0005);
    chk("R9 state kept", state, 64'd5);
    chk("R9 err", {63'd0, err}, 64'd1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule